// File: doc/BRIEF.md
# Paired-Channel Fractional-Duty PWM Array

This block drives eight output pins, grouped into four fixed pairs (channels 0 and 1, 2 and 3, 4 and 5, 6 and 7). Each pair has one period counter. The counter divides the reference clock by an integer N, so both channels of a pair always share one frequency. Each channel has its own duty word, counted in sixteenths of a reference-clock cycle. The four fractional bits are dithered across a frame of sixteen periods, so the average duty resolves to one sixteenth of a cycle.

Each pin is set to one of three modes: PWM, general-purpose output, or off. A pin that drives can work push-pull or as an active-low open drain. Configuration arrives through a single-cycle register write port. A new divisor or duty word is held in a shadow register and moves into use only at the pair's next period boundary. When one channel of a pair is switched to PWM, its companion follows, but only if the companion is switched off at that moment.

Top module: `pwm_pair_array`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every pin is a push-pull output driving low (`pin_o` = 0, `pin_oe` = 1). Every channel resets to output mode with level 0, every active divisor is 2 and every duty word is 0.
- R2: A pair's period lasts exactly N reference cycles, where N is the divisor in use. Within each period, a PWM channel is high for the first cycles and low for the rest.
- R3: Take a duty word D = 16·W + F, with F in D[3:0]. The channel is high for W+1 cycles in F of every 16 consecutive periods and for W cycles in the others. Any window of 16·N cycles therefore holds exactly D high cycles.
- R4: A duty word of 0 holds the output low. A duty word of 16·N or more holds it high for the whole period.
- R5: A written divisor or duty word takes effect only at the start of the pair's next period. The period in progress completes with the old values.
- R6: Writes use `wr_sel`. `wr_sel`=0 writes the divisor of pair `wr_idx[1:0]`. `wr_sel`=1 writes the duty word of channel `wr_idx`. `wr_sel`=2 writes the mode of channel `wr_idx` from `wr_data[1:0]`: 1 selects output mode, 2 selects PWM, and 0 or 3 selects off. `wr_sel`=3 writes the drive of channel `wr_idx`: `wr_data[0]` is the level and `wr_data[1]` selects open drain. In push-pull output mode, `pin_o` follows the level and `pin_oe` is 1 two cycles after the write.
- R7: In open-drain drive, `pin_o` is always 0 and `pin_oe` is asserted only while the pin's value is low. This holds in both output mode and PWM mode.
- R8: Writing PWM mode to a channel also puts its companion into PWM mode when the companion is off. A companion that is in output mode keeps its mode.
- R9: A channel in off mode releases its pin (`pin_oe` = 0, `pin_o` = 0).
- R10: A divisor write below 2 is stored as 2. A divisor write above 16383 is stored as 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: divisor, duty, mode or drive |
| wr_idx | input | 3 | Channel index (pair index in bits 1:0 for divisor writes) |
| wr_data | input | 18 | Write value |
| pin_o | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The hardest situation to reach is a write that lands in the middle of a period. The shadow value must stay out of use until the wrap, even though the pins show nothing of the counter's phase.

The stimulus sets up a pair with a long period and rewrites its divisor and duty word at an arbitrary cycle. A cycle-accurate behavioural model in the bench wraps on its own count. Every pin is compared against it on every clock, so a load that comes early or late shows up as a mismatch.

The fractional dither is checked by counting high cycles over sixteen whole periods. A further check measures the distance between rising edges after clamped divisor writes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_GPO = 2'd1,
        MODE_PWM = 2'd2
    } pin_mode_e;

    typedef enum logic [1:0] {
        SEL_DIV   = 2'd0,
        SEL_DUTY  = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_DRIVE = 2'd3
    } wr_sel_e;

    typedef struct packed {
        pin_mode_e mode;
        logic      level;
        logic      od;
    } pin_cfg_t;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int DIV_W     = 14,
    parameter int FRAC_W    = 4
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     wr_en,
    input  logic [1:0]                               wr_sel,
    input  logic [$clog2(2*NUM_PAIRS)-1:0]           wr_idx,
    input  logic [DIV_W+FRAC_W-1:0]                  wr_data,
    output logic [NUM_PAIRS-1:0][DIV_W-1:0]          sh_div,
    output logic [2*NUM_PAIRS-1:0][DIV_W+FRAC_W-1:0] sh_duty,
    output pin_cfg_t [2*NUM_PAIRS-1:0]               pin_cfg
);
    localparam int NCH     = 2 * NUM_PAIRS;
    localparam int CH_W    = $clog2(NCH);
    localparam int PAIR_W  = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
    localparam int DUTY_W  = DIV_W + FRAC_W;
    localparam int DIV_MAX = (1 << DIV_W) - 1;
    localparam int DIV_MIN = 2;

    typedef struct packed {
        logic [NUM_PAIRS-1:0][DIV_W-1:0] div;
        logic [NCH-1:0][DUTY_W-1:0]      duty;
        pin_cfg_t [NCH-1:0]              cfg;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    pin_mode_e  new_mode;
    logic [CH_W-1:0]   mate;
    logic [PAIR_W-1:0] pair_sel;

    always_comb begin
        s_d      = s_q;
        mate     = wr_idx ^ CH_W'(1);
        pair_sel = PAIR_W'(wr_idx);
        case (wr_data[1:0])
            2'd1:    new_mode = MODE_GPO;
            2'd2:    new_mode = MODE_PWM;
            default: new_mode = MODE_OFF;
        endcase
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_DIV: begin
                    if (wr_data < DUTY_W'(DIV_MIN))
                        s_d.div[pair_sel] = DIV_W'(DIV_MIN);
                    else if (wr_data > DUTY_W'(DIV_MAX))
                        s_d.div[pair_sel] = DIV_W'(DIV_MAX);
                    else
                        s_d.div[pair_sel] = wr_data[DIV_W-1:0];
                end
                SEL_DUTY: s_d.duty[wr_idx] = wr_data;
                SEL_MODE: begin
                    s_d.cfg[wr_idx].mode = new_mode;
                    if (new_mode == MODE_PWM && s_q.cfg[mate].mode == MODE_OFF)
                        s_d.cfg[mate].mode = MODE_PWM;
                end
                default: begin
                    s_d.cfg[wr_idx].level = wr_data[0];
                    s_d.cfg[wr_idx].od    = wr_data[1];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PAIRS; p++) s_q.div[p] <= DIV_W'(DIV_MIN);
            for (int c = 0; c < NCH; c++) begin
                s_q.duty[c] <= '0;
                s_q.cfg[c]  <= '{mode: MODE_GPO, level: 1'b0, od: 1'b0};
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign sh_div  = s_q.div;
    assign sh_duty = s_q.duty;
    assign pin_cfg = s_q.cfg;

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
    parameter int DIV_W  = 14,
    parameter int FRAC_W = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [DIV_W-1:0]                 sh_div,
    input  logic [1:0][DIV_W+FRAC_W-1:0]     sh_duty,
    output logic [1:0]                       wave,
    output logic [DIV_W-1:0]                 cnt_o,
    output logic [DIV_W-1:0]                 div_o
);
    localparam int DUTY_W = DIV_W + FRAC_W;

    typedef struct packed {
        logic [DIV_W-1:0]       cnt;
        logic [FRAC_W-1:0]      frame;
        logic [DIV_W-1:0]       div;
        logic [1:0][DUTY_W-1:0] duty;
    } timer_state_t;

    timer_state_t t_d, t_q;
    logic [1:0][DIV_W:0] thr;

    always_comb begin
        t_d = t_q;
        if (t_q.cnt == t_q.div - DIV_W'(1)) begin
            t_d.cnt   = '0;
            t_d.frame = t_q.frame + FRAC_W'(1);
            t_d.div   = sh_div;
            t_d.duty  = sh_duty;
        end else begin
            t_d.cnt = t_q.cnt + DIV_W'(1);
        end
        for (int k = 0; k < 2; k++) begin
            thr[k]  = {1'b0, t_q.duty[k][DUTY_W-1:FRAC_W]}
                    + (DIV_W+1)'(t_q.frame < t_q.duty[k][FRAC_W-1:0]);
            wave[k] = {1'b0, t_q.cnt} < thr[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q.cnt   <= '0;
            t_q.frame <= '0;
            t_q.div   <= DIV_W'(2);
            t_q.duty  <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt_o = t_q.cnt;
    assign div_o = t_q.div;

endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wave,
    input  pin_cfg_t cfg,
    output logic     pin_o,
    output logic     pin_oe
);
    typedef struct packed {
        logic o;
        logic oe;
    } drv_t;

    drv_t d_d, d_q;
    logic val;

    always_comb begin
        val = (cfg.mode == MODE_PWM) ? wave : cfg.level;
        if (cfg.mode == MODE_OFF) begin
            d_d.o  = 1'b0;
            d_d.oe = 1'b0;
        end else if (cfg.od) begin
            d_d.o  = 1'b0;
            d_d.oe = ~val;
        end else begin
            d_d.o  = val;
            d_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q.o  <= 1'b0;
            d_q.oe <= 1'b1;
        end else begin
            d_q <= d_d;
        end
    end

    assign pin_o  = d_q.o;
    assign pin_oe = d_q.oe;

endmodule

// File: rtl/pwm_pair_array.sv
module pwm_pair_array
    import pwm_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int DIV_W     = 14,
    parameter int FRAC_W    = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [1:0]                         wr_sel,
    input  logic [$clog2(2*NUM_PAIRS)-1:0]     wr_idx,
    input  logic [DIV_W+FRAC_W-1:0]            wr_data,
    output logic [2*NUM_PAIRS-1:0]             pin_o,
    output logic [2*NUM_PAIRS-1:0]             pin_oe
);
    localparam int NCH    = 2 * NUM_PAIRS;
    localparam int DUTY_W = DIV_W + FRAC_W;

    logic [NUM_PAIRS-1:0][DIV_W-1:0] sh_div;
    logic [NCH-1:0][DUTY_W-1:0]      sh_duty;
    pin_cfg_t [NCH-1:0]              pin_cfg;
    logic [NCH-1:0]                  wave;
    logic [NUM_PAIRS-1:0][DIV_W-1:0] pair_cnt;
    logic [NUM_PAIRS-1:0][DIV_W-1:0] pair_div;

    pwm_cfg_regs #(
        .NUM_PAIRS(NUM_PAIRS), .DIV_W(DIV_W), .FRAC_W(FRAC_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .sh_div(sh_div), .sh_duty(sh_duty), .pin_cfg(pin_cfg)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pwm_pair_timer #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_timer (
            .clk(clk), .rst(rst),
            .sh_div(sh_div[p]),
            .sh_duty(sh_duty[2*p+1 -: 2]),
            .wave(wave[2*p+1 -: 2]),
            .cnt_o(pair_cnt[p]),
            .div_o(pair_div[p])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_pin
        pwm_pin_drive u_drive (
            .clk(clk), .rst(rst), .wave(wave[c]), .cfg(pin_cfg[c]),
            .pin_o(pin_o[c]), .pin_oe(pin_oe[c])
        );
    end

endmodule

// File: rtl/pwm_array_chk.sv
module pwm_array_chk #(
    parameter int NUM_PAIRS = 4,
    parameter int DIV_W     = 14
) (
    input logic                            clk,
    input logic                            rst,
    input logic [2*NUM_PAIRS-1:0]          pin_o,
    input logic [2*NUM_PAIRS-1:0]          pin_oe,
    input logic [NUM_PAIRS-1:0][DIV_W-1:0] pair_cnt,
    input logic [NUM_PAIRS-1:0][DIV_W-1:0] pair_div
);
    // R1
    reset_pins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_o == '0 && pin_oe == '1));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        // R2
        cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
            (pair_cnt[p] != '0) |-> (pair_cnt[p] == $past(pair_cnt[p]) + DIV_W'(1)));
        // R2
        cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
            pair_cnt[p] < pair_div[p]);
        // R5
        div_boundary_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(pair_div[p]) |-> (pair_cnt[p] == '0));
    end

    for (genvar c = 0; c < 2*NUM_PAIRS; c++) begin : g_pin
        // R7
        release_low_chk: assert property (@(posedge clk) disable iff (rst)
            !pin_oe[c] |-> !pin_o[c]);
    end
endmodule

bind pwm_pair_array pwm_array_chk #(.NUM_PAIRS(NUM_PAIRS), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .pin_o(pin_o), .pin_oe(pin_oe),
    .pair_cnt(pair_cnt), .pair_div(pair_div)
);

// File: tb/tb_pwm_pair_array.sv
module tb_pwm_pair_array;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [2:0]  wr_idx = '0;
    logic [17:0] wr_data = '0;
    logic [7:0]  pin_o, pin_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pwm_pair_array dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    // behavioural reference model
    int sdiv[4], adiv[4], cnt[4], frm[4];
    int sduty[8], aduty[8], mode[8], lvl[8], od[8];
    logic [7:0] e_o = '0, e_oe = '1;

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 4; p++) begin
                sdiv[p] = 2; adiv[p] = 2; cnt[p] = 0; frm[p] = 0;
            end
            for (int c = 0; c < 8; c++) begin
                sduty[c] = 0; aduty[c] = 0; mode[c] = 1; lvl[c] = 0; od[c] = 0;
            end
            e_o = '0; e_oe = '1;
        end else begin
            for (int c = 0; c < 8; c++) begin
                int p; bit v;
                p = c / 2;
                if (mode[c] == 2)
                    v = cnt[p] < (aduty[c] / 16 + ((frm[p] < aduty[c] % 16) ? 1 : 0));
                else
                    v = lvl[c][0];
                if (mode[c] == 0) begin e_o[c] = 0; e_oe[c] = 0; end
                else if (od[c] != 0) begin e_o[c] = 0; e_oe[c] = !v; end
                else begin e_o[c] = v; e_oe[c] = 1; end
            end
            for (int p = 0; p < 4; p++) begin
                if (cnt[p] == adiv[p] - 1) begin
                    cnt[p] = 0; frm[p] = (frm[p] + 1) % 16; adiv[p] = sdiv[p];
                    aduty[2*p] = sduty[2*p]; aduty[2*p+1] = sduty[2*p+1];
                end else cnt[p]++;
            end
            if (wr_en) begin
                int d, i;
                d = int'(wr_data); i = int'(wr_idx);
                case (wr_sel)
                    2'd0: sdiv[i % 4] = (d < 2) ? 2 : (d > 16383) ? 16383 : d;
                    2'd1: sduty[i] = d;
                    2'd2: begin
                        mode[i] = (d % 4 == 1) ? 1 : (d % 4 == 2) ? 2 : 0;
                        if (mode[i] == 2 && mode[i ^ 1] == 0) mode[i ^ 1] = 2;
                    end
                    default: begin lvl[i] = d % 2; od[i] = (d / 2) % 2; end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk)
        if (!rst && !done)
            chk({pin_o, pin_oe} == {e_o, e_oe}, cur_req, "pins vs model",
                {pin_o, pin_oe}, {e_o, e_oe});

    task automatic wr(input int sel, input int idx, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_idx = idx[2:0]; wr_data = data[17:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_hi(input int ch, input int n, input bit use_oe, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hits += use_oe ? int'(!pin_oe[ch]) : int'(pin_o[ch]);
        end
    endtask

    task automatic rise_gap(input int ch, output int gap);
        logic prev;
        prev = pin_o[ch];
        forever begin
            @(negedge clk);
            if (pin_o[ch] && !prev) break;
            prev = pin_o[ch];
        end
        gap = 0;
        prev = pin_o[ch];
        forever begin
            @(negedge clk);
            gap++;
            if (pin_o[ch] && !prev) break;
            prev = pin_o[ch];
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pin_o == 8'h00 && pin_oe == 8'hFF, "R1", "reset pins", {pin_o, pin_oe}, 16'h00FF);
        rst = 1'b0;
        @(negedge clk);
        chk(pin_o == 8'h00 && pin_oe == 8'hFF, "R1", "first cycle", {pin_o, pin_oe}, 16'h00FF);

        // R6: push-pull output level
        cur_req = "R6";
        wr(3, 0, 1);
        @(negedge clk);
        chk(pin_o[0] == 1'b1 && pin_oe[0] == 1'b1, "R6", "gpo high", {pin_o[0], pin_oe[0]}, 2'b11);
        wr(3, 0, 0);
        @(negedge clk);
        chk(pin_o[0] == 1'b0 && pin_oe[0] == 1'b1, "R6", "gpo low", {pin_o[0], pin_oe[0]}, 2'b01);

        // R2: period of N cycles, channel 1 stays in output mode (R8)
        cur_req = "R2";
        wr(0, 0, 5); wr(1, 0, 32); wr(2, 0, 2);
        repeat (20) @(negedge clk);
        rise_gap(0, n);
        chk(n == 5, "R2", "period N=5", n, 5);
        count_hi(0, 80, 0, n);
        chk(n == 32, "R2", "2 of 5 cycles high", n, 32);
        chk(pin_oe[1] == 1'b1 && pin_o[1] == 1'b0, "R8", "output-mode companion kept",
            {pin_o[1], pin_oe[1]}, 2'b01);

        // R3: fractional duty dither
        cur_req = "R3";
        wr(1, 0, 37);
        repeat (12) @(negedge clk);
        count_hi(0, 80, 0, n);
        chk(n == 37, "R3", "dither 37/16 per period", n, 37);

        // R9 then R8: off companion follows into PWM
        cur_req = "R9";
        wr(2, 3, 0);
        @(negedge clk);
        chk(pin_oe[3] == 1'b0 && pin_o[3] == 1'b0, "R9", "off pin released", {pin_o[3], pin_oe[3]}, 2'b00);
        cur_req = "R8";
        wr(0, 1, 4); wr(1, 3, 24); wr(2, 2, 2);
        repeat (16) @(negedge clk);
        count_hi(3, 64, 0, n);
        chk(n == 24, "R8", "auto-enabled companion duty", n, 24);

        // R4: duty extremes
        cur_req = "R4";
        wr(1, 0, 0);
        repeat (12) @(negedge clk);
        count_hi(0, 80, 0, n);
        chk(n == 0, "R4", "zero duty low", n, 0);
        wr(1, 0, 80);
        repeat (12) @(negedge clk);
        count_hi(0, 80, 0, n);
        chk(n == 80, "R4", "duty 16N high", n, 80);
        wr(1, 0, 5000);
        repeat (12) @(negedge clk);
        count_hi(0, 80, 0, n);
        chk(n == 80, "R4", "duty above 16N high", n, 80);

        // R7: open drain in PWM mode
        cur_req = "R7";
        wr(1, 0, 32); wr(3, 0, 2);
        repeat (12) @(negedge clk);
        count_hi(0, 80, 1, n);
        chk(n == 32, "R7", "released cycles", n, 32);
        chk(pin_o[0] == 1'b0, "R7", "od pin_o low", pin_o[0], 0);

        // R5: mid-period updates wait for the wrap
        cur_req = "R5";
        wr(0, 2, 200); wr(1, 4, 16 * 60); wr(2, 4, 2);
        repeat (450) @(negedge clk);
        repeat (37) @(negedge clk);
        wr(0, 2, 3); wr(1, 4, 16);
        repeat (300) @(negedge clk);
        rise_gap(4, n);
        chk(n == 3, "R5", "new period after wrap", n, 3);

        // R10: divisor clamping
        cur_req = "R10";
        wr(0, 3, 0); wr(1, 6, 16); wr(2, 6, 2);
        repeat (12) @(negedge clk);
        count_hi(6, 32, 0, n);
        chk(n == 16, "R10", "low clamp to 2", n, 16);
        wr(0, 3, 20000); wr(1, 6, 1600);
        rise_gap(6, n);
        rise_gap(6, n);
        chk(n == 16383, "R10", "high clamp to 16383", n, 16383);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule